// File: doc/BRIEF.md
# Shared-Clock Lane Refresh Controller

This block drives a bank of latched serial-in shift-register chips arranged as a grid of rows and columns. Each chip, or each short cascade of chips, has its own serial data lane. Every lane uses one common shift clock and one common latch strobe. Because the clock and strobe are shared, a frame rewrites every chip at once. The block therefore holds a shadow copy of every chip's word, and in each frame it sends back the unchanged contents of chips the host did not touch.

A host writes one chip at a time, giving its row, column and data word. The write lands in the shadow copy and marks that chip dirty. When any entry is dirty, or when the host pulses a refresh request, the frame engine takes a snapshot of the whole shadow image. It then shifts all lanes together, most significant bit first, and finishes with a latch pulse. When nothing is pending, the shift clock and latch stay low. The shift clock comes from the system clock through a divider parameter, so the rate can be kept within the chips' limit (15 MHz at most, with roughly 0.5 to 1 MHz per cascaded chip as the usual target).

Top module: `lane_refresh_ctrl`

## Requirements
- R1: After reset, `sclk`, `latch`, `busy` and every `sdo` bit are 0. Every shadow word is 0 and no entry is dirty.
- R2: When no entry is dirty and `refresh_req` is low, no frame starts, and `sclk` and `latch` stay 0. When the engine is idle and some entry is dirty, a frame starts on the next clock edge.
- R3: A write with `wr_en` high stores `wr_data` for chip index `wr_row*COLS + wr_col` and marks that entry dirty. A write with `wr_row >= ROWS` or `wr_col >= COLS` changes neither the shadow image nor the dirty marks.
- R4: One frame gives exactly `CHAIN*W` rising edges of `sclk`. On each lane L, the bits sent are the lane word sent MSB first. Chip `L*CHAIN + p` fills bits `[(CHAIN-1-p)*W +: W]` of that word, so chain position 0 is sent first.
- R5: Chips that were not written in a frame receive the word they already hold, so a refresh frame repeats the previous image exactly.
- R6: `sdo` changes only while `sclk` is low. It is stable for the whole time `sclk` is high.
- R7: Each high phase and each low phase of `sclk` within a frame lasts exactly `HALF` system clocks. The first rising edge comes `HALF` clocks after `busy` rises.
- R8: The latch pulse starts `HALF` clocks after the last falling edge of `sclk`. It stays high for exactly `2*HALF` clocks, and `sclk` is low for all of that time.
- R9: `busy` rises on the clock edge where a frame starts. It falls on the same edge where `latch` falls. `sclk` and `latch` are both low whenever `busy` is low.
- R10: A frame sends the image it captured at its start. A write that arrives during a frame, or in the same cycle the frame starts, is sent in the following frame.
- R11: A `refresh_req` pulse seen while the engine is idle starts a frame, even when no entry is dirty.
- R12: Dirty marks are cleared when the snapshot is taken. After a frame, with no new write and no refresh request, no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_row | input | clog2(ROWS) | Row of the chip to update |
| wr_col | input | clog2(COLS) | Column of the chip to update |
| wr_data | input | W | New register word for the chip |
| refresh_req | input | 1 | Request a frame even with nothing dirty |
| sdo | output | ROWS*COLS/CHAIN | Serial data, one bit per lane |
| sclk | output | 1 | Shared shift clock |
| latch | output | 1 | Shared latch strobe |
| busy | output | 1 | High from frame start until the latch pulse ends |

## Verification
The hardest case to reach is a host write that arrives while a frame is in progress, and in particular one that lands in the exact cycle the snapshot is taken. The frame in progress must send the old word, and the following frame must send the new one. The stimulus first uses a directed step that waits for `busy` and then writes mid-frame. It then runs a long random phase in which writes, out-of-range writes and refresh pulses are timed with no regard to frame boundaries, so snapshot-cycle collisions occur many times. A bench model captures its own copy of the image when `busy` rises and compares every lane's captured bits when `latch` rises.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    // frame engine phases
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_LATCH = 2'd2
    } fr_state_t;

endpackage

// File: rtl/lrc_tick.sv
// Half-period tick generator for the shared shift clock.
module lrc_tick #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tk_t;

    tk_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        tick = 1'b0;
        if (!en) begin
            tk_d.cnt = '0;
        end else if (tk_q.cnt == CW'(HALF - 1)) begin
            tk_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            tk_d.cnt = tk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

endmodule

// File: rtl/lrc_shadow.sv
// Shadow image of every chip word plus per-chip dirty marks.
module lrc_shadow #(
    parameter int ROWS = 4,
    parameter int COLS = 5,
    parameter int W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] wr_row,
    input  logic [((COLS>1)?$clog2(COLS):1)-1:0] wr_col,
    input  logic [W-1:0]                     wr_data,
    input  logic                             clr,
    output logic [ROWS*COLS-1:0][W-1:0]      image,
    output logic                             dirty_any
);
    localparam int CHIPS = ROWS * COLS;
    localparam int IW    = (CHIPS > 1) ? $clog2(CHIPS) : 1;

    typedef struct packed {
        logic [CHIPS-1:0][W-1:0] mem;
        logic [CHIPS-1:0]        dirty;
    } sh_t;

    sh_t sh_d, sh_q;

    logic          row_ok, col_ok, wvalid;
    logic [IW-1:0] widx;

    always_comb begin
        row_ok = (32'(wr_row) < 32'(ROWS));
        col_ok = (32'(wr_col) < 32'(COLS));
        wvalid = wr_en && row_ok && col_ok;
        widx   = IW'(32'(wr_row) * 32'(COLS) + 32'(wr_col));
    end

    always_comb begin
        sh_d = sh_q;
        if (clr) sh_d.dirty = '0;
        for (int c = 0; c < CHIPS; c++) begin
            if (wvalid && (widx == IW'(c))) begin
                sh_d.mem[c]   = wr_data;
                sh_d.dirty[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign image     = sh_q.mem;
    assign dirty_any = |sh_q.dirty;

    // R3
    wr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |=> sh_q.dirty[$past(widx)]);

    // R3
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wvalid) |=> $stable(sh_q.mem));

    // R12
    dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (sh_q.dirty == '0));

endmodule

// File: rtl/lrc_frame.sv
// Frame engine: snapshot, parallel shift of every lane, latch pulse.
module lrc_frame
    import lrc_pkg::*;
#(
    parameter int LANES = 20,
    parameter int BITS  = 8,
    parameter int HALF  = 25
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        start_ok,
    input  logic [LANES-1:0][BITS-1:0]  lane_words,
    output logic                        snap,
    output logic [LANES-1:0]            sdo,
    output logic                        sclk,
    output logic                        latch,
    output logic                        busy
);
    localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int GW  = $clog2(4 * HALF + 2);

    typedef struct packed {
        fr_state_t                 st;
        logic [LANES-1:0][BITS-1:0] sh;
        logic [BCW-1:0]            bitcnt;
        logic                      sclk;
        logic                      latch;
        logic                      lph;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        snap = 1'b0;
        unique case (fr_q.st)
            FR_IDLE: begin
                if (start_ok) begin
                    fr_d.st     = FR_SHIFT;
                    fr_d.sh     = lane_words;
                    fr_d.bitcnt = '0;
                    snap        = 1'b1;
                end
            end
            FR_SHIFT: begin
                if (tick) begin
                    if (!fr_q.sclk) begin
                        fr_d.sclk = 1'b1;
                    end else begin
                        fr_d.sclk = 1'b0;
                        if (fr_q.bitcnt == BCW'(BITS - 1)) begin
                            fr_d.st = FR_LATCH;
                        end else begin
                            fr_d.bitcnt = fr_q.bitcnt + 1'b1;
                            for (int l = 0; l < LANES; l++)
                                fr_d.sh[l] = fr_q.sh[l] << 1;
                        end
                    end
                end
            end
            FR_LATCH: begin
                if (tick) begin
                    if (!fr_q.latch) begin
                        fr_d.latch = 1'b1;
                    end else if (!fr_q.lph) begin
                        fr_d.lph = 1'b1;
                    end else begin
                        fr_d.latch = 1'b0;
                        fr_d.lph   = 1'b0;
                        fr_d.st    = FR_IDLE;
                    end
                end
            end
            default: fr_d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_sdo
            assign sdo[l] = fr_q.sh[l][BITS-1];
        end
    endgenerate

    assign sclk  = fr_q.sclk;
    assign latch = fr_q.latch;
    assign busy  = (fr_q.st != FR_IDLE);

    // cycles since the last shift-clock change, for the period check
    logic          sclk_prev_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            gap_q       <= '0;
        end else begin
            sclk_prev_q <= sclk;
            if (!busy)                         gap_q <= '0;
            else if (sclk != sclk_prev_q)      gap_q <= GW'(1);
            else if (gap_q != {GW{1'b1}})      gap_q <= gap_q + 1'b1;
        end
    end

    // R7
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_prev_q) |-> (gap_q == GW'(HALF)));

    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sclk_prev_q) |-> $stable(sdo));

    // R8
    latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !sclk);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !latch));

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(latch));

endmodule

// File: rtl/lane_refresh_ctrl.sv
// Top: shadow image, divider and frame engine for a grid of latched
// shift-register chips sharing one shift clock and one latch strobe.
module lane_refresh_ctrl #(
    parameter int ROWS  = 4,
    parameter int COLS  = 5,
    parameter int W     = 8,
    parameter int CHAIN = 1,
    parameter int HALF  = 25
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] wr_row,
    input  logic [((COLS>1)?$clog2(COLS):1)-1:0] wr_col,
    input  logic [W-1:0]                         wr_data,
    input  logic                                 refresh_req,
    output logic [ROWS*COLS/CHAIN-1:0]           sdo,
    output logic                                 sclk,
    output logic                                 latch,
    output logic                                 busy
);
    localparam int CHIPS = ROWS * COLS;
    localparam int LANES = CHIPS / CHAIN;
    localparam int BITS  = CHAIN * W;

    logic [CHIPS-1:0][W-1:0]     image;
    logic [LANES-1:0][BITS-1:0]  lane_words;
    logic                        dirty_any;
    logic                        snap;
    logic                        tick;

    lrc_shadow #(
        .ROWS (ROWS),
        .COLS (COLS),
        .W    (W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .wr_col    (wr_col),
        .wr_data   (wr_data),
        .clr       (snap),
        .image     (image),
        .dirty_any (dirty_any)
    );

    // chain position 0 occupies the top bits of the lane word
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            for (genvar p = 0; p < CHAIN; p++) begin : g_pos
                assign lane_words[l][(CHAIN-1-p)*W +: W] = image[l*CHAIN + p];
            end
        end
    endgenerate

    lrc_tick #(
        .HALF (HALF)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    lrc_frame #(
        .LANES (LANES),
        .BITS  (BITS),
        .HALF  (HALF)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start_ok   (dirty_any | refresh_req),
        .lane_words (lane_words),
        .snap       (snap),
        .sdo        (sdo),
        .sclk       (sclk),
        .latch      (latch),
        .busy       (busy)
    );

endmodule

// File: tb/lane_refresh_ctrl_test.sv
module lane_refresh_ctrl_test;
    localparam int ROWS  = 4;
    localparam int COLS  = 5;
    localparam int W     = 8;
    localparam int CHAIN = 2;
    localparam int HALF  = 3;
    localparam int CHIPS = ROWS * COLS;
    localparam int LANES = CHIPS / CHAIN;
    localparam int BITS  = CHAIN * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_row = '0;
    logic [2:0] wr_col = '0;
    logic [W-1:0] wr_data = '0;
    logic refresh_req = 1'b0;
    logic [LANES-1:0] sdo;
    logic sclk, latch, busy;

    always #2.5 clk = ~clk;

    lane_refresh_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .W(W), .CHAIN(CHAIN), .HALF(HALF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .refresh_req(refresh_req),
        .sdo(sdo), .sclk(sclk), .latch(latch), .busy(busy)
    );

    int total = 0;
    int bad   = 0;
    int frames = 0;

    logic [W-1:0]    mdl  [CHIPS];
    logic [W-1:0]    snapm[CHIPS];
    logic            mdirty[CHIPS];
    logic [BITS-1:0] cap  [LANES];
    int nbits = 0, gap = 0, lw = 0;
    logic p_sclk = 0, p_latch = 0, p_busy = 0;
    logic [LANES-1:0] p_sdo = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BITS-1:0] exp_lane(input int l);
        logic [BITS-1:0] v;
        for (int p = 0; p < CHAIN; p++)
            v[(CHAIN-1-p)*W +: W] = snapm[l*CHAIN + p];
        return v;
    endfunction

    function automatic bit any_dirty();
        for (int c = 0; c < CHIPS; c++) if (mdirty[c]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        for (int c = 0; c < CHIPS; c++) begin
            mdl[c] = '0; snapm[c] = '0; mdirty[c] = 1'b0;
        end
        for (int l = 0; l < LANES; l++) cap[l] = '0;
    end

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit dbefore;
            dbefore = any_dirty();
            // R2 / R11: idle engine must start when work is pending
            if (!p_busy && (dbefore || refresh_req))
                chk(busy, dbefore ? "R2" : "R11", "frame start", busy, 1);
            if (busy && !p_busy) begin
                // R12: a frame starts only with work pending
                chk(dbefore || refresh_req, "R12", "start without work", 1, 0);
                for (int c = 0; c < CHIPS; c++) begin
                    snapm[c] = mdl[c]; mdirty[c] = 1'b0;
                end
                nbits = 0; gap = 0;
                for (int l = 0; l < LANES; l++) cap[l] = '0;
            end else if (busy) begin
                gap++;
            end
            if (!busy) begin
                // R9 / R2
                chk(!sclk && !latch, "R9", "idle outputs", {sclk, latch}, 0);
            end
            if (busy && sclk != p_sclk) begin
                // R7
                chk(gap == HALF, "R7", "sclk phase length", gap, HALF);
                gap = 0;
                if (sclk) begin
                    for (int l = 0; l < LANES; l++)
                        cap[l] = {cap[l][BITS-2:0], sdo[l]};
                    nbits++;
                end
            end
            if (sclk && p_sclk)  // R6
                chk(sdo == p_sdo, "R6", "sdo moved while sclk high", sdo, p_sdo);
            if (latch && !p_latch) begin
                // R8
                chk(gap == HALF && !sclk, "R8", "latch delay", gap, HALF);
                // R4
                chk(nbits == BITS, "R4", "bit count", nbits, BITS);
                for (int l = 0; l < LANES; l++)  // R4 / R5 / R10
                    chk(cap[l] == exp_lane(l), "R5", $sformatf("lane %0d data", l),
                        cap[l], exp_lane(l));
                lw = 1;
            end else if (latch && p_latch) begin
                lw++;
            end
            if (!latch && p_latch) begin
                // R8 / R9
                chk(lw == 2 * HALF, "R8", "latch width", lw, 2 * HALF);
                chk(!busy, "R9", "busy falls with latch", busy, 0);
                frames++;
            end
            if (!busy && p_busy)
                chk(p_latch && !latch, "R9", "busy fall timing", p_latch, 1);
            // R3: apply host write to the model after the snapshot
            if (wr_en && wr_row < ROWS && wr_col < COLS) begin
                mdl[wr_row * COLS + wr_col]    = wr_data;
                mdirty[wr_row * COLS + wr_col] = 1'b1;
            end
            p_sclk = sclk; p_latch = latch; p_busy = busy; p_sdo = sdo;
        end
    end

    task automatic do_write(input int r, input int c, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(r); wr_col = 3'(c); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_refresh();
        @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
    endtask

    task automatic settle();
        int guard = 0;
        @(negedge clk);
        @(negedge clk);
        while ((busy || any_dirty()) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int f0;
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sclk == 0 && latch == 0 && busy == 0 && sdo == '0, "R1", "reset outputs",
            {sdo, sclk, latch, busy}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        // R2: nothing pending, no frame
        chk(frames == 0 && !busy, "R2", "idle with nothing dirty", frames, 0);

        // R11 / R1: refresh with nothing dirty sends the all-zero image
        pulse_refresh();
        settle();
        chk(frames == 1, "R11", "refresh frame count", frames, 1);

        // R12: no repeat frame without new work
        f0 = frames;
        repeat (100) @(negedge clk);
        chk(frames == f0, "R12", "no frame after dirty cleared", frames, f0);

        // R3: out-of-range columns are ignored
        do_write(1, 5, 8'hFF);
        do_write(3, 7, 8'h77);
        repeat (60) @(negedge clk);
        chk(frames == f0 && !busy, "R3", "bad address starts no frame", frames, f0);
        pulse_refresh();
        settle();  // lane data compare shows image unchanged (R3, R5)

        // corner chips: first and last index
        do_write(0, 0, 8'h3C);
        do_write(3, 4, 8'hA5);
        settle();

        // R10: write during a frame goes to the next frame
        f0 = frames;
        do_write(2, 2, 8'h11);
        while (!busy) @(negedge clk);
        repeat (HALF * 5) @(negedge clk);
        do_write(2, 2, 8'hEE);
        settle();
        chk(frames == f0 + 2, "R10", "mid-frame write gives a second frame",
            frames, f0 + 2);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 6)
                do_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
                         W'($urandom));
            else if (op == 6)
                do_write(int'($urandom_range(0, 3)), int'($urandom_range(5, 7)),
                         W'($urandom));
            else if (op == 7)
                pulse_refresh();
            else
                repeat (int'($urandom_range(0, 40))) @(negedge clk);
        end
        settle();
        pulse_refresh();
        settle();
        chk(!busy && !any_dirty(), "R12", "final idle", busy, 0);
        finish_run();
    end
endmodule